// File: doc/BRIEF.md
# PMP Configuration Bank

This block holds the programming state of a physical-memory-protection unit. It has a fixed number of protection entries. Each entry has an 8-bit configuration byte and an address register. A single security-control register sits beside them. Software reaches all of this through one register port: a write strobe, a register class, a register index, write data, and combinational read data. Every write is screened against locking rules before it lands. Configuration writes are screened one byte at a time.

The address-range checker sits downstream and reads the decoded entry fields directly from this block. Those fields are: read, write and execute permission, match mode, lock and address. The security-control register supplies the checker's policy flags: machine lockdown, whitelist policy, and a rule-lock bypass.

Four entries share one 32-bit configuration register. Entry `4*k+i` lives in byte `i` of configuration register `k`. The security register lives at index 0 of its class.

Top module: `pmp_cfg_bank`

## Requirements
- R1: Register class encoding on `csrKind` is: 0 configuration, 1 address, 2 security, 3 unused. Configuration register k, byte i (bits 8i+7:8i), is the byte of entry 4k+i, and reads return the stored bytes packed that way. Within a byte: bit 0 is read permission, bit 1 write, bit 2 execute, bits 4:3 match mode (01 = top-of-range), and bit 7 lock. These appear on the per-entry decode outputs one cycle after an accepted write.
- R2: While the bypass bit is set, every configuration byte write is accepted, whether or not the entry is locked and whatever the lockdown state.
- R3: With bypass and lockdown both clear, a configuration byte write is accepted exactly when the target entry's lock bit (bit 7) is clear.
- R4: With lockdown set and bypass clear, the target entry's lock is not consulted. A byte write is accepted in two cases and rejected otherwise:
  - the new byte has bit 7 set and bit 2 clear; or
  - the new byte has bit 7 clear and its bits 2:0 are not exactly 3'b110.
- R5: An address write to entry n is dropped in either of two cases:
  - entry n is locked; or
  - entry n+1 exists, is locked, and has match mode 01.

  The last entry depends only on its own lock. The bypass bit does not affect address writes.
- R6: Bit 2 of a security write can raise the bypass bit only when no entry is locked. A write with bit 2 clear always clears it.
- R7: Lockdown and whitelist are sticky. Once set, they stay set until reset, whatever is written.
- R8: These writes are ignored and these reads return zero:
  - configuration index at or above NUM_ENTRIES/4;
  - address index at or above NUM_ENTRIES;
  - security index other than 0;
  - class 3.
- R9: Reset clears every configuration byte, address register and security bit.
- R10: The security register holds lockdown at bit 0, whitelist at bit 1 and bypass at bit 2. Bits 31:3 are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWe | input | 1 | Write strobe |
| csrKind | input | 2 | Register class (R1 encoding) |
| csrIdx | input | IDX_W | Register index within the class |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Combinational read data for the addressed register |
| entryRead | output | NUM_ENTRIES | Per-entry read permission |
| entryWrite | output | NUM_ENTRIES | Per-entry write permission |
| entryExec | output | NUM_ENTRIES | Per-entry execute permission |
| entryMode | output | 2*NUM_ENTRIES | Per-entry match mode, entry e at bits 2e+1:2e |
| entryLock | output | NUM_ENTRIES | Per-entry lock |
| entryAddr | output | NUM_ENTRIES*ADDR_W | Per-entry address register, entry e at slice e |
| secLockdown | output | 1 | Machine lockdown flag |
| secWhitelist | output | 1 | Whitelist policy flag |
| secBypass | output | 1 | Rule-lock bypass flag |

## Verification
The bench builds the bank with the defaults: 16 entries, 32-bit addresses and a 6-bit index. With 16 entries there are four configuration registers, so a single write hits four entries that get different accept decisions. Entries follow locked top-of-range and locked non-top-of-range neighbours, and the last entry has no neighbour at all. The 6-bit index reaches well past both the configuration range and the address range, so rejected and zero-reading indices are covered.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } regKind_e;

  localparam int BYTES_PER_CFG = 4;
  localparam int BIT_READ      = 0;
  localparam int BIT_WRITE     = 1;
  localparam int BIT_EXEC      = 2;
  localparam int BIT_MODE_LO   = 3;
  localparam int BIT_LOCK      = 7;
  localparam logic [1:0] MODE_TOR = 2'b01;
  localparam logic [2:0] PERM_WX  = 3'b110;

  // secVal: [2] bypass, [1] whitelist, [0] lockdown
  typedef struct packed {
    logic [BYTES_PER_CFG-1:0] cfgByteWe;
    logic                     addrWe;
    logic                     secWe;
    logic [2:0]               secVal;
  } bankStrobe_t;

endpackage

// File: rtl/pmp_bank_ctrl.sv
module pmp_bank_ctrl
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csrWe,
  input  logic [1:0]               csrKind,
  input  logic [IDX_W-1:0]         csrIdx,
  input  logic [31:0]              csrWdata,
  input  logic [NUM_ENTRIES*8-1:0] cfgFlat,
  input  logic                     secLockdown,
  input  logic                     secWhitelist,
  input  logic                     secBypass,
  output bankStrobe_t              strobe
);

  localparam int ENT_W    = $clog2(NUM_ENTRIES);
  localparam int CFG_REGS = NUM_ENTRIES / BYTES_PER_CFG;
  localparam int CFG_W    = $clog2(CFG_REGS);

  logic [7:0] cfgArr [NUM_ENTRIES];
  logic       anyLock;
  logic       kindCfg, kindAddr, kindSec;
  logic       cfgInRange, addrInRange;
  logic [ENT_W-1:0] addrSel, nextSel;
  logic       isLast, nextBlocks, ownLocked;
  logic       unusedCfg;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_unpack
    assign cfgArr[e] = cfgFlat[e*8 +: 8];
  end

  assign unusedCfg = ^cfgFlat;

  always_comb begin
    anyLock = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) anyLock = anyLock | cfgArr[e][BIT_LOCK];
  end

  assign kindCfg     = (csrKind == KIND_CFG);
  assign kindAddr    = (csrKind == KIND_ADDR);
  assign kindSec     = (csrKind == KIND_SEC);
  assign cfgInRange  = int'(csrIdx) < CFG_REGS;
  assign addrInRange = int'(csrIdx) < NUM_ENTRIES;

  // per-byte acceptance for a configuration write
  for (genvar b = 0; b < BYTES_PER_CFG; b++) begin : g_byte
    logic [ENT_W-1:0] entSel;
    logic [7:0]       newByte;
    logic             curLock, lockdownOk, accept;
    assign entSel     = {csrIdx[CFG_W-1:0], 2'(b)};
    assign newByte    = csrWdata[b*8 +: 8];
    assign curLock    = cfgArr[entSel][BIT_LOCK];
    assign lockdownOk = (newByte[BIT_LOCK] & ~newByte[BIT_EXEC]) |
                        (~newByte[BIT_LOCK] & (newByte[2:0] != PERM_WX));
    assign accept     = secBypass |
                        (~secLockdown & ~curLock) |
                        (secLockdown & lockdownOk);
    assign strobe.cfgByteWe[b] = csrWe & kindCfg & cfgInRange & accept;
  end

  // address write screening against own and next entry
  assign addrSel    = csrIdx[ENT_W-1:0];
  assign nextSel    = addrSel + 1'b1;
  assign isLast     = (addrSel == ENT_W'(NUM_ENTRIES - 1));
  assign ownLocked  = cfgArr[addrSel][BIT_LOCK];
  assign nextBlocks = ~isLast & cfgArr[nextSel][BIT_LOCK] &
                      (cfgArr[nextSel][BIT_MODE_LO +: 2] == MODE_TOR);
  assign strobe.addrWe = csrWe & kindAddr & addrInRange & ~ownLocked & ~nextBlocks;

  // security register: sticky policy bits, guarded bypass
  assign strobe.secWe     = csrWe & kindSec & (csrIdx == '0);
  assign strobe.secVal[2] = csrWdata[2] & (secBypass | ~anyLock);
  assign strobe.secVal[1] = csrWdata[1] | secWhitelist;
  assign strobe.secVal[0] = csrWdata[0] | secLockdown;

  AST_OOR_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && kindCfg && !cfgInRange) |=> $stable(cfgFlat)); // R8

  AST_BAD_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrKind == KIND_NONE) |=> $stable(cfgFlat)); // R8

endmodule

// File: rtl/pmp_bank_dp.sv
module pmp_bank_dp
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobe_t                   strobe,
  input  logic [1:0]                    csrKind,
  input  logic [IDX_W-1:0]              csrIdx,
  input  logic [31:0]                   csrWdata,
  output logic [NUM_ENTRIES*8-1:0]      cfgFlat,
  output logic [NUM_ENTRIES*ADDR_W-1:0] addrFlat,
  output logic                          secLockdown,
  output logic                          secWhitelist,
  output logic                          secBypass,
  output logic [31:0]                   csrRdata
);

  localparam int ENT_W    = $clog2(NUM_ENTRIES);
  localparam int CFG_REGS = NUM_ENTRIES / BYTES_PER_CFG;
  localparam int CFG_W    = $clog2(CFG_REGS);

  logic [7:0]        cfgArr  [NUM_ENTRIES];
  logic [ADDR_W-1:0] addrArr [NUM_ENTRIES];
  logic              lockdownQ, whitelistQ, bypassQ;
  logic              anyLockDp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        cfgArr[e]  <= '0;
        addrArr[e] <= '0;
      end
      lockdownQ  <= 1'b0;
      whitelistQ <= 1'b0;
      bypassQ    <= 1'b0;
    end else begin
      for (int b = 0; b < BYTES_PER_CFG; b++) begin
        if (strobe.cfgByteWe[b])
          cfgArr[{csrIdx[CFG_W-1:0], 2'(b)}] <= csrWdata[b*8 +: 8];
      end
      if (strobe.addrWe) addrArr[csrIdx[ENT_W-1:0]] <= csrWdata[ADDR_W-1:0];
      if (strobe.secWe) begin
        bypassQ    <= strobe.secVal[2];
        whitelistQ <= strobe.secVal[1];
        lockdownQ  <= strobe.secVal[0];
      end
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_flat
    assign cfgFlat[e*8 +: 8]           = cfgArr[e];
    assign addrFlat[e*ADDR_W +: ADDR_W] = addrArr[e];
  end

  assign secLockdown  = lockdownQ;
  assign secWhitelist = whitelistQ;
  assign secBypass    = bypassQ;

  always_comb begin
    csrRdata = '0;
    unique case (csrKind)
      KIND_CFG: if (int'(csrIdx) < CFG_REGS)
        for (int b = 0; b < BYTES_PER_CFG; b++)
          csrRdata[b*8 +: 8] = cfgArr[{csrIdx[CFG_W-1:0], 2'(b)}];
      KIND_ADDR: if (int'(csrIdx) < NUM_ENTRIES)
        csrRdata = 32'(addrArr[csrIdx[ENT_W-1:0]]);
      KIND_SEC: if (csrIdx == '0)
        csrRdata = {29'd0, bypassQ, whitelistQ, lockdownQ};
      default: csrRdata = '0;
    endcase
  end

  always_comb begin
    anyLockDp = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) anyLockDp = anyLockDp | cfgArr[e][BIT_LOCK];
  end

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockdownQ |=> lockdownQ); // R7

  AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    whitelistQ |=> whitelistQ); // R7

  AST_BYPASS_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassQ && anyLockDp) |=> !bypassQ); // R6

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!bypassQ && !lockdownQ && cfgArr[e][BIT_LOCK]) |=> $stable(cfgArr[e])); // R3

    AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      cfgArr[e][BIT_LOCK] |=> $stable(addrArr[e])); // R5
  end

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csrWe,
  input  logic [1:0]                    csrKind,
  input  logic [IDX_W-1:0]              csrIdx,
  input  logic [31:0]                   csrWdata,
  output logic [31:0]                   csrRdata,
  output logic [NUM_ENTRIES-1:0]        entryRead,
  output logic [NUM_ENTRIES-1:0]        entryWrite,
  output logic [NUM_ENTRIES-1:0]        entryExec,
  output logic [2*NUM_ENTRIES-1:0]      entryMode,
  output logic [NUM_ENTRIES-1:0]        entryLock,
  output logic [NUM_ENTRIES*ADDR_W-1:0] entryAddr,
  output logic                          secLockdown,
  output logic                          secWhitelist,
  output logic                          secBypass
);

  bankStrobe_t              strobe;
  logic [NUM_ENTRIES*8-1:0] cfgFlat;
  logic                     unusedCfgBits;

  pmp_bank_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .csrWe        (csrWe),
    .csrKind      (csrKind),
    .csrIdx       (csrIdx),
    .csrWdata     (csrWdata),
    .cfgFlat      (cfgFlat),
    .secLockdown  (secLockdown),
    .secWhitelist (secWhitelist),
    .secBypass    (secBypass),
    .strobe       (strobe)
  );

  pmp_bank_dp #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .csrKind      (csrKind),
    .csrIdx       (csrIdx),
    .csrWdata     (csrWdata),
    .cfgFlat      (cfgFlat),
    .addrFlat     (entryAddr),
    .secLockdown  (secLockdown),
    .secWhitelist (secWhitelist),
    .secBypass    (secBypass),
    .csrRdata     (csrRdata)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_dec
    assign entryRead[e]       = cfgFlat[e*8 + BIT_READ];
    assign entryWrite[e]      = cfgFlat[e*8 + BIT_WRITE];
    assign entryExec[e]       = cfgFlat[e*8 + BIT_EXEC];
    assign entryMode[2*e +: 2] = cfgFlat[e*8 + BIT_MODE_LO +: 2];
    assign entryLock[e]       = cfgFlat[e*8 + BIT_LOCK];
  end

  assign unusedCfgBits = ^cfgFlat;

endmodule

// File: tb/tb_pmp_cfg_bank.sv
module tb_pmp_cfg_bank;

  localparam int N  = 16;
  localparam int AW = 32;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csrWe = 1'b0;
  logic [1:0]    csrKind = 2'd0;
  logic [IW-1:0] csrIdx = '0;
  logic [31:0]   csrWdata = '0;
  logic [31:0]   csrRdata;
  logic [N-1:0]  entryRead, entryWrite, entryExec, entryLock;
  logic [2*N-1:0] entryMode;
  logic [N*AW-1:0] entryAddr;
  logic          secLockdown, secWhitelist, secBypass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit [7:0]  mCfg  [N];
  bit [31:0] mAddr [N];
  bit        mLd, mWl, mBp;

  pmp_cfg_bank #(.NUM_ENTRIES(N), .ADDR_W(AW), .IDX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrKind(csrKind), .csrIdx(csrIdx),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .entryRead(entryRead),
    .entryWrite(entryWrite), .entryExec(entryExec), .entryMode(entryMode),
    .entryLock(entryLock), .entryAddr(entryAddr), .secLockdown(secLockdown),
    .secWhitelist(secWhitelist), .secBypass(secBypass)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit cfgAccept(int ent, bit [7:0] nb);
    if (mBp) return 1;
    if (!mLd) return !mCfg[ent][7];
    return (nb[7] && !nb[2]) || (!nb[7] && nb[2:0] != 3'b110);
  endfunction

  task automatic modelWrite(int kind, int idx, bit [31:0] data);
    bit anyL = 0;
    if (kind == 0 && idx < N/4) begin
      for (int b = 0; b < 4; b++)
        if (cfgAccept(idx*4+b, data[b*8 +: 8])) mCfg[idx*4+b] = data[b*8 +: 8];
    end else if (kind == 1 && idx < N) begin
      bit blocked = mCfg[idx][7];
      if (idx < N-1 && mCfg[idx+1][7] && mCfg[idx+1][4:3] == 2'b01) blocked = 1;
      if (!blocked) mAddr[idx] = data;
    end else if (kind == 2 && idx == 0) begin
      for (int e = 0; e < N; e++) if (mCfg[e][7]) anyL = 1;
      mBp = data[2] && (mBp || !anyL);
      mWl = mWl || data[1];
      mLd = mLd || data[0];
    end
  endtask

  function automatic bit [31:0] modelRead(int kind, int idx);
    bit [31:0] v = 0;
    if (kind == 0 && idx < N/4)
      for (int b = 0; b < 4; b++) v[b*8 +: 8] = mCfg[idx*4+b];
    else if (kind == 1 && idx < N) v = mAddr[idx];
    else if (kind == 2 && idx == 0) v = {29'd0, mBp, mWl, mLd};
    return v;
  endfunction

  task automatic compareAll(string tag);
    logic [95:0] actDec, expDec;
    logic [511:0] expAddr;
    for (int e = 0; e < N; e++) begin
      actDec[e*6 +: 6] = {entryLock[e], entryMode[2*e +: 2], entryExec[e], entryWrite[e], entryRead[e]};
      expDec[e*6 +: 6] = {mCfg[e][7], mCfg[e][4:3], mCfg[e][2], mCfg[e][1], mCfg[e][0]};
      expAddr[e*32 +: 32] = mAddr[e];
    end
    chk(tag, "decode", 512'(actDec), 512'(expDec));
    chk(tag, "addr", 512'(entryAddr), expAddr);
    chk(tag, "sec", 512'({secBypass, secWhitelist, secLockdown}), 512'({mBp, mWl, mLd}));
  endtask

  task automatic wr(int kind, int idx, bit [31:0] data, string tag);
    @(negedge clk);
    csrWe = 1'b1; csrKind = 2'(kind); csrIdx = IW'(idx); csrWdata = data;
    @(posedge clk);
    modelWrite(kind, idx, data);
    @(negedge clk);
    csrWe = 1'b0;
    compareAll(tag);
  endtask

  task automatic rd(int kind, int idx, string tag);
    @(negedge clk);
    csrKind = 2'(kind); csrIdx = IW'(idx);
    #2;
    chk(tag, "readback", 512'(csrRdata), 512'(modelRead(kind, idx)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N; e++) begin mCfg[e] = 0; mAddr[e] = 0; end
    mLd = 0; mWl = 0; mBp = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    compareAll("R9");
    rd(0, 0, "R9"); rd(1, 5, "R9"); rd(2, 0, "R9");
    // R1 byte layout and packing
    wr(0, 0, 32'h1D170E01, "R1");
    wr(0, 2, 32'h60050218, "R1");
    rd(0, 0, "R1"); rd(0, 2, "R1");
    wr(1, 0, 32'h00001000, "R5");
    wr(1, 3, 32'hDEADBEEF, "R5");
    rd(1, 3, "R5");
    // R6 bypass may rise with nothing locked
    wr(2, 0, 32'h4, "R6");
    rd(2, 0, "R6");
    // R2 bypass allows rewriting locked entries
    wr(0, 1, 32'h80808C8F, "R2");
    wr(0, 1, 32'h81810000, "R2");
    wr(0, 1, 32'h99998989, "R2");
    rd(0, 1, "R2");
    wr(2, 0, 32'h0, "R6");
    wr(2, 0, 32'h4, "R6");
    rd(2, 0, "R6");
    // R3 plain locking
    wr(0, 1, 32'h00000000, "R3");
    wr(0, 0, 32'h03030303, "R3");
    rd(0, 1, "R3");
    // R5 address write screening
    wr(0, 2, 32'h88009800, "R5");
    wr(0, 3, 32'h80000000, "R5");
    wr(1, 4, 32'h11111111, "R5");
    wr(1, 3, 32'h22222222, "R5");
    wr(1, 8, 32'h33333333, "R5");
    wr(1, 9, 32'h44444444, "R5");
    wr(1, 10, 32'h55555555, "R5");
    wr(1, 15, 32'h66666666, "R5");
    wr(1, 14, 32'h77777777, "R5");
    rd(1, 8, "R5"); rd(1, 10, "R5"); rd(1, 14, "R5");
    // R8 out-of-range accesses
    wr(0, 4, 32'hFFFFFFFF, "R8");
    wr(1, 16, 32'hFFFFFFFF, "R8");
    wr(2, 1, 32'h7, "R8");
    wr(3, 0, 32'hFFFFFFFF, "R8");
    rd(0, 4, "R8"); rd(1, 20, "R8"); rd(2, 1, "R8"); rd(3, 0, "R8"); rd(0, 63, "R8");
    // R10 upper security bits not stored
    wr(2, 0, 32'hFFFFFFF8, "R10");
    rd(2, 0, "R10");
    // R7 sticky policy bits
    wr(2, 0, 32'h2, "R7");
    wr(2, 0, 32'h0, "R7");
    wr(2, 0, 32'h1, "R7");
    wr(2, 0, 32'h0, "R7");
    rd(2, 0, "R7");
    // R4 lockdown write rules
    wr(0, 0, 32'h07068184, "R4");
    wr(0, 1, 32'h8386018D, "R4");
    rd(0, 0, "R4"); rd(0, 1, "R4");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule